// File: doc/BRIEF.md
# I/O Wait-State and Keyboard-Interrupt Responder

This block sits on the peripheral side of an 8-bit Z80-style bus. It stalls each true I/O cycle by pulling the wait line low until the cycle has been dealt with. The responder answers some ports itself: the key-available status, the key byte and the interrupt acknowledge. Console output and warm-boot reload go to a slower back-end through a request/done handshake. The CPU runs in interrupt mode 1. Cycles where the I/O strobe and the opcode-fetch strobe are both low are interrupt-acknowledge cycles. The block lets these pass untouched: it adds no wait state, does not drive the bus and sends no request.

When a key byte is pushed in, the block holds it and drives the interrupt line low. The line stays low until the CPU writes any value to port 0x38. The control strobes are resynchronized into the block clock before edge detection. The address and write data are taken as stable while the CPU is stalled. Read data is latched when the cycle is decoded, so it stays constant until the strobe rises.

Top module: `z80_io_responder`

## Requirements
- R1: While iorq_n is low and m1_n is high, wait_n is low from the first clock after iorq_n falls until the cycle has been serviced.
- R2: For a back-end port, be_req stays high and wait_n stays low until be_done is seen. wait_n then returns high.
- R3: A cycle with m1_n and iorq_n both low causes no wait state, no be_req and no bus drive.
- R4: A key_push drives int_n low on the next clock. int_n stays low through other accesses until a write of any value to port 0x38, which drives int_n high.
- R5: A read of port 2 returns 0x01 if a key is held and 0x00 if not. A read of port 3 returns the held key byte and clears the held flag.
- R6: A write to port 4 raises be_req with be_op = 2 and be_wdata equal to the written byte.
- R7: A write to port 1 raises be_req with be_op = 1.
- R8: Any other port, or any read of a write-only port, pulses bad_port for one clock. The cycle finishes without be_req, and a read returns 0xFF.
- R9: cpu_d_oe is high only during a serviced read cycle with m1_n high, and never during a write or while be_req is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| m1_n | input | 1 | Opcode-fetch / acknowledge strobe, active low |
| cpu_addr | input | 8 | Low address byte (port number) |
| cpu_d_in | input | 8 | Data bus as seen from the CPU |
| cpu_d_out | output | 8 | Data driven toward the CPU |
| cpu_d_oe | output | 1 | Enable for the data bus driver |
| wait_n | output | 1 | Wait request, active low |
| int_n | output | 1 | Maskable interrupt request, active low |
| key_push | input | 1 | One-clock strobe: new key byte available |
| key_byte | input | 8 | Key byte captured with key_push |
| be_req | output | 1 | Back-end operation pending |
| be_op | output | 2 | Operation: 1 warm-boot reload, 2 console byte |
| be_wdata | output | 8 | Byte for the back-end |
| be_done | input | 1 | Back-end finished the pending operation |
| bad_port | output | 1 | One-clock pulse on an unsupported access |

## Verification
A stuck cycle state would show as wait_n held low forever, so the CPU hangs. The bench can see this within a few hundred clocks. A lost transition to the finished state would show as wait_n rising before be_done, or as the bus driven on a write, at the first sampled clock after decode. A corrupted key or interrupt flag shows at once on int_n or in the next port 2 or port 3 read. A failure to filter acknowledge cycles shows as wait_n or be_req going low or high during an acknowledge, within three clocks of the strobe.

// File: rtl/z80io_pkg.sv
package z80io_pkg;
   typedef enum logic [1:0] {
      OP_NONE   = 2'd0,
      OP_BOOT   = 2'd1,
      OP_CONOUT = 2'd2
   } be_op_e;

   typedef enum logic [1:0] {
      CYC_IDLE = 2'd0,
      CYC_BUSY = 2'd1,
      CYC_DONE = 2'd2
   } cyc_state_e;
endpackage

// File: rtl/z80io_sync.sv
module z80io_sync #(
   parameter int               WIDTH   = 4,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] d_sync
);
   initial begin
      assert (STAGES >= 2) else $fatal(1, "z80io_sync: STAGES must be at least 2");
      assert (WIDTH >= 1) else $fatal(1, "z80io_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d_async;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign d_sync = stg[STAGES-1];
endmodule

// File: rtl/z80io_keyreg.sv
module z80io_keyreg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              take,
   input  logic              int_clr,
   output logic              avail,
   output logic [DATA_W-1:0] key_q,
   output logic              int_pend
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         avail    <= 1'b0;
         key_q    <= '0;
         int_pend <= 1'b0;
      end else begin
         if (push) begin
            avail <= 1'b1;
            key_q <= push_data;
         end else if (take) begin
            avail <= 1'b0;
         end
         if (push)         int_pend <= 1'b1;
         else if (int_clr) int_pend <= 1'b0;
      end
   end

   AST_PUSH_RAISES_INT: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> (int_pend && avail)); // R4
   AST_ACK_DROPS_INT: assert property (@(posedge clk) disable iff (!rst_n)
      (int_clr && !push) |=> !int_pend); // R4
   AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !push) |=> !avail); // R5
endmodule

// File: rtl/z80io_cycle.sv
module z80io_cycle
   import z80io_pkg::*;
#(
   parameter int                ADDR_W    = 8,
   parameter int                DATA_W    = 8,
   parameter logic [ADDR_W-1:0] PORT_BOOT = ADDR_W'(1),
   parameter logic [ADDR_W-1:0] PORT_STAT = ADDR_W'(2),
   parameter logic [ADDR_W-1:0] PORT_KEY  = ADDR_W'(3),
   parameter logic [ADDR_W-1:0] PORT_CON  = ADDR_W'(4),
   parameter logic [ADDR_W-1:0] PORT_ACK  = ADDR_W'(56)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iorq_s,
   input  logic              rd_s,
   input  logic              wr_s,
   input  logic              m1_s,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              avail,
   input  logic [DATA_W-1:0] key_q,
   input  logic              be_done,
   output cyc_state_e        state,
   output logic [DATA_W-1:0] rdata_q,
   output logic              be_req,
   output be_op_e            be_op,
   output logic [DATA_W-1:0] be_wdata,
   output logic              take,
   output logic              int_clr,
   output logic              bad_port
);
   logic              iorq_prev;
   logic              start;
   logic              need_be;
   be_op_e            op_d;
   logic [DATA_W-1:0] rd_val;

   assign start = iorq_prev && !iorq_s && m1_s && (state == CYC_IDLE);

   always_comb begin
      need_be  = 1'b0;
      op_d     = OP_NONE;
      rd_val   = '1;
      take     = 1'b0;
      int_clr  = 1'b0;
      bad_port = 1'b0;
      if (start) begin
         if (!rd_s) begin
            if (addr == PORT_STAT) begin
               rd_val = avail ? DATA_W'(1) : '0;
            end else if (addr == PORT_KEY) begin
               rd_val = key_q;
               take   = 1'b1;
            end else begin
               bad_port = 1'b1;
            end
         end else if (!wr_s) begin
            if (addr == PORT_BOOT) begin
               need_be = 1'b1;
               op_d    = OP_BOOT;
            end else if (addr == PORT_CON) begin
               need_be = 1'b1;
               op_d    = OP_CONOUT;
            end else if (addr == PORT_ACK) begin
               int_clr = 1'b1;
            end else begin
               bad_port = 1'b1;
            end
         end else begin
            bad_port = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iorq_prev <= 1'b1;
         state     <= CYC_IDLE;
         rdata_q   <= '1;
         be_op     <= OP_NONE;
         be_wdata  <= '0;
      end else begin
         iorq_prev <= iorq_s;
         unique case (state)
            CYC_IDLE: if (start) begin
               if (need_be) begin
                  state    <= CYC_BUSY;
                  be_op    <= op_d;
                  be_wdata <= wdata;
               end else begin
                  state   <= CYC_DONE;
                  rdata_q <= rd_val;
               end
            end
            CYC_BUSY: if (be_done) state <= CYC_DONE;
            CYC_DONE: if (iorq_s) state <= CYC_IDLE;
            default:  state <= CYC_IDLE;
         endcase
      end
   end

   assign be_req = (state == CYC_BUSY);

   AST_ACK_CYCLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (iorq_prev && !iorq_s && !m1_s && state == CYC_IDLE) |=> (state == CYC_IDLE)); // R3
   AST_REQ_HELD_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (be_req && !be_done) |=> be_req); // R2
   AST_BAD_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      bad_port |=> !be_req); // R8
endmodule

// File: rtl/z80_io_responder.sv
module z80_io_responder
   import z80io_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iorq_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              m1_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_d_in,
   output logic [DATA_W-1:0] cpu_d_out,
   output logic              cpu_d_oe,
   output logic              wait_n,
   output logic              int_n,
   input  logic              key_push,
   input  logic [DATA_W-1:0] key_byte,
   output logic              be_req,
   output logic [1:0]        be_op,
   output logic [DATA_W-1:0] be_wdata,
   input  logic              be_done,
   output logic              bad_port
);
   localparam int CTRL_W = 4;

   initial begin
      assert (ADDR_W >= 6) else $fatal(1, "z80_io_responder: ADDR_W too small for port 0x38");
      assert (DATA_W >= 2) else $fatal(1, "z80_io_responder: DATA_W too small");
   end

   logic [CTRL_W-1:0] ctrl_s;
   logic              iorq_s, rd_s, wr_s, m1_s;
   logic              avail, int_pend, take, int_clr;
   logic [DATA_W-1:0] key_q;
   cyc_state_e        state;
   be_op_e            be_op_e_w;

   z80io_sync #(.WIDTH(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async ({iorq_n, rd_n, wr_n, m1_n}),
      .d_sync  (ctrl_s)
   );
   assign {iorq_s, rd_s, wr_s, m1_s} = ctrl_s;

   z80io_keyreg #(.DATA_W(DATA_W)) u_key (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (key_push),
      .push_data (key_byte),
      .take      (take),
      .int_clr   (int_clr),
      .avail     (avail),
      .key_q     (key_q),
      .int_pend  (int_pend)
   );

   z80io_cycle #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cyc (
      .clk      (clk),
      .rst_n    (rst_n),
      .iorq_s   (iorq_s),
      .rd_s     (rd_s),
      .wr_s     (wr_s),
      .m1_s     (m1_s),
      .addr     (cpu_addr),
      .wdata    (cpu_d_in),
      .avail    (avail),
      .key_q    (key_q),
      .be_done  (be_done),
      .state    (state),
      .rdata_q  (cpu_d_out),
      .be_req   (be_req),
      .be_op    (be_op_e_w),
      .be_wdata (be_wdata),
      .take     (take),
      .int_clr  (int_clr),
      .bad_port (bad_port)
   );

   assign be_op    = be_op_e_w;
   assign wait_n   = !(!iorq_n && m1_n && (state != CYC_DONE));
   assign int_n    = !int_pend;
   assign cpu_d_oe = !iorq_n && !rd_n && m1_n && (state == CYC_DONE);

   AST_WAIT_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (be_req && !iorq_n && m1_n) |-> !wait_n); // R1
   AST_NO_DRIVE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      !m1_n |-> !cpu_d_oe); // R3
   AST_NO_DRIVE_WHILE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_d_oe |-> !be_req); // R9
endmodule

// File: tb/z80_io_responder_tb_top.sv
module z80_io_responder_tb_top;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       iorq_n, rd_n, wr_n, m1_n;
   logic [7:0] cpu_addr, cpu_d_in, cpu_d_out, key_byte, be_wdata;
   logic       cpu_d_oe, wait_n, int_n, key_push, be_req, be_done, bad_port;
   logic [1:0] be_op;

   int n_run  = 0;
   int n_fail = 0;
   int err_cnt = 0;

   typedef struct { logic [1:0] op; logic [7:0] data; } be_item_t;
   be_item_t exp_q[$];

   always #5 clk = ~clk;

   z80_io_responder dut_i (
      .clk(clk), .rst_n(rst_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n),
      .cpu_addr(cpu_addr), .cpu_d_in(cpu_d_in), .cpu_d_out(cpu_d_out), .cpu_d_oe(cpu_d_oe),
      .wait_n(wait_n), .int_n(int_n), .key_push(key_push), .key_byte(key_byte),
      .be_req(be_req), .be_op(be_op), .be_wdata(be_wdata), .be_done(be_done),
      .bad_port(bad_port)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) if (rst_n && bad_port) err_cnt++;

   // Back-end model and scoreboard monitor: pops the expected item on each request
   initial begin
      be_done = 1'b0;
      forever begin
         @(negedge clk);
         if (be_req && !be_done) begin
            repeat (4) @(negedge clk);
            chk(wait_n == 1'b0 && be_req, "R2", "wait held while back-end busy", int'(wait_n), 0);
            if (exp_q.size() == 0) begin
               chk(1'b0, "R6", "unexpected back-end request", int'(be_op), 0);
            end else begin
               be_item_t it;
               it = exp_q.pop_front();
               chk(be_op == it.op, it.op == 2'd2 ? "R6" : "R7", "back-end op", int'(be_op), int'(it.op));
               chk(be_wdata == it.data, it.op == 2'd2 ? "R6" : "R7", "back-end data", int'(be_wdata), int'(it.data));
            end
            be_done = 1'b1;
            @(negedge clk);
            be_done = 1'b0;
         end
      end
   end

   task automatic cpu_io(input bit is_wr, input logic [7:0] port, input logic [7:0] wd,
                         output logic [7:0] rd);
      int guard;
      @(negedge clk);
      cpu_addr = port;
      cpu_d_in = wd;
      m1_n     = 1'b1;
      iorq_n   = 1'b0;
      if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
      @(negedge clk);
      chk(wait_n == 1'b0, "R1", "wait low after strobe", int'(wait_n), 0);
      guard = 0;
      while (wait_n == 1'b0 && guard < 200) begin
         @(negedge clk);
         guard++;
      end
      chk(wait_n == 1'b1, "R2", "wait released", int'(wait_n), 1);
      chk(cpu_d_oe == !is_wr, "R9", "bus drive matches direction", int'(cpu_d_oe), int'(!is_wr));
      rd     = cpu_d_out;
      iorq_n = 1'b1;
      rd_n   = 1'b1;
      wr_n   = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic push_key(input logic [7:0] v);
      @(negedge clk);
      key_push = 1'b1;
      key_byte = v;
      @(negedge clk);
      key_push = 1'b0;
      chk(int_n == 1'b0, "R4", "int low after key push", int'(int_n), 0);
   endtask

   task automatic finish_run;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      logic [7:0] r;
      int e0;
      rst_n = 1'b0; iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; m1_n = 1'b1;
      cpu_addr = '0; cpu_d_in = '0; key_push = 1'b0; key_byte = '0;
      repeat (3) @(negedge clk);
      chk(wait_n && int_n && !be_req && !cpu_d_oe && !bad_port, "R1", "reset state",
          int'({wait_n, int_n, be_req, cpu_d_oe, bad_port}), 'b11000);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      cpu_io(1'b0, 8'h02, 8'h00, r);
      chk(r == 8'h00, "R5", "status with no key", int'(r), 0);

      push_key(8'h41);
      cpu_io(1'b0, 8'h02, 8'h00, r);
      chk(r == 8'h01, "R5", "status with key", int'(r), 1);
      cpu_io(1'b0, 8'h03, 8'h00, r);
      chk(r == 8'h41, "R5", "key byte", int'(r), 'h41);
      cpu_io(1'b0, 8'h02, 8'h00, r);
      chk(r == 8'h00, "R5", "status after key read", int'(r), 0);
      chk(int_n == 1'b0, "R4", "int held across reads", int'(int_n), 0);

      // acknowledge cycle: M1 and IORQ both low
      @(negedge clk);
      m1_n = 1'b0;
      @(negedge clk);
      iorq_n = 1'b0;
      begin
         bit clean = 1'b1;
         repeat (6) begin
            @(negedge clk);
            if (!wait_n || be_req || cpu_d_oe) clean = 1'b0;
         end
         chk(clean, "R3", "acknowledge cycle untouched", int'({wait_n, be_req, cpu_d_oe}), 'b100);
      end
      iorq_n = 1'b1;
      m1_n   = 1'b1;
      repeat (4) @(negedge clk);
      chk(int_n == 1'b0, "R4", "int held after acknowledge cycle", int'(int_n), 0);

      cpu_io(1'b1, 8'h38, 8'hA5, r);
      chk(int_n == 1'b1, "R4", "int cleared by port 0x38 write", int'(int_n), 1);

      exp_q.push_back('{op: 2'd2, data: 8'h5A});
      cpu_io(1'b1, 8'h04, 8'h5A, r);
      exp_q.push_back('{op: 2'd1, data: 8'h00});
      cpu_io(1'b1, 8'h01, 8'h00, r);
      exp_q.push_back('{op: 2'd2, data: 8'hC3});
      cpu_io(1'b1, 8'h04, 8'hC3, r);
      chk(exp_q.size() == 0, "R6", "all back-end items consumed", exp_q.size(), 0);

      e0 = err_cnt;
      cpu_io(1'b0, 8'h10, 8'h00, r);
      chk(r == 8'hFF, "R8", "unsupported read data", int'(r), 'hFF);
      chk(err_cnt == e0 + 1, "R8", "error pulse on unsupported read", err_cnt - e0, 1);
      cpu_io(1'b1, 8'h99, 8'h12, r);
      chk(err_cnt == e0 + 2, "R8", "error pulse on unsupported write", err_cnt - e0, 2);
      cpu_io(1'b0, 8'h04, 8'h00, r);
      chk(r == 8'hFF && err_cnt == e0 + 3, "R8", "read of write-only port", int'(r), 'hFF);

      push_key(8'h7E);
      push_key(8'h20);
      cpu_io(1'b0, 8'h03, 8'h00, r);
      chk(r == 8'h20, "R5", "newest key byte held", int'(r), 'h20);

      repeat (5) @(negedge clk);
      finish_run();
   end
endmodule